// File: doc/BRIEF.md
# Interrupt Priority and Exception Vector Unit

This unit decides, once per clock, whether the processor leaves its current instruction stream for a firmware handler, and if so where it goes. It looks at four pending interrupt lines, the current interrupt priority level and the privileged firmware-mode flag. It also sees a synchronous exception request with its cause code. For a call-gate exception it receives an 8-bit gate code as well.

When a dispatch happens, the unit produces four results. The return address is the current PC with the mode flag folded into bit 0. The new PC is the firmware base register plus a cause-dependent offset. The outgoing mode flag is set to privileged, and a single-cycle dispatch pulse marks the event. Fixed causes use a table of 128-byte-spaced entries. Call gates land in one of two banks of 64-byte slots, chosen by bit 7 of the gate code.

All outputs are registered. Inputs sampled at one rising edge appear on the outputs right after that edge. The mode flag itself is owned by the surrounding core. The unit reports the mode value the core should adopt next.

Top module: `irq_vector_unit`

## Requirements
- R1: While reset is high, and after it, until the first dispatch, `dsp_valid_o`, `bad_code_o` and `priv_o` are 0, and `dsp_pc_o`, `dsp_ret_o`, `dsp_cause_o` and `dsp_err_o` are 0.
- R2: A synchronous exception whose code is 0..9 dispatches with `dsp_pc_o` = `fw_base_i` + offset. The codes and offsets are: reset 0 → 0x000, machine check 1 → 0x080, inter-processor 2 → 0x100, clock 3 → 0x180, device 4 → 0x200, memory fault 5 → 0x280, unaligned 6 → 0x300, illegal opcode 7 → 0x380, arithmetic 8 → 0x400, FP disabled 9 → 0x480. Inputs sampled at one rising edge give a `dsp_valid_o` pulse of one cycle just after that edge.
- R3: Code 10 is the call gate. A gate code g with bit 7 clear gives offset 0x1000 + g×64. With bit 7 set the offset is 0x2000 + (g−0x80)×64.
- R4: On dispatch, `dsp_ret_o` equals the sampled PC with bit 0 ORed with the sampled `fw_mode_i`, and `priv_o` is 1.
- R5: Interrupt line bits are `irq_i[0]` device, `irq_i[1]` clock, `irq_i[2]` inter-processor and `irq_i[3]` machine check. A line may be taken only when `ipl_i` is at most its ceiling: device 3, clock 4, inter-processor 5, machine check 6. No line is taken at level 7.
- R6: Among allowed pending lines the winner is machine check, then inter-processor, then clock, then device. `dsp_cause_o` reports the winner's code from R2 (1, 2, 3 or 4).
- R7: While `fw_mode_i` is 1, no interrupt is taken.
- R8: A synchronous exception with a valid code is taken even while `fw_mode_i` is 1. It wins over any pending interrupt in the same cycle, and `dsp_cause_o` reports its code.
- R9: `dsp_err_o` is the gate code for a call-gate dispatch and 0 for every other dispatch, interrupts included.
- R10: An exception code of 11..15 pulses `bad_code_o` for one cycle. That cycle has no dispatch, not even of a pending interrupt, and `dsp_pc_o` keeps its previous value.
- R11: In a cycle without dispatch, `dsp_valid_o` is 0, `priv_o` follows the sampled `fw_mode_i`, and `dsp_pc_o`, `dsp_ret_o`, `dsp_cause_o` and `dsp_err_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 4 | Pending interrupt lines (device, clock, inter-processor, machine check) |
| ipl_i | input | IPL_W | Current interrupt priority level |
| fw_mode_i | input | 1 | Current privileged firmware-mode flag |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 4 | Exception cause code |
| gate_code_i | input | 8 | Call-gate code |
| pc_i | input | PC_W | Current PC |
| fw_base_i | input | PC_W | Firmware base address |
| dsp_valid_o | output | 1 | One-cycle dispatch pulse |
| dsp_pc_o | output | PC_W | New PC of the last dispatch |
| dsp_ret_o | output | PC_W | Saved return address of the last dispatch |
| dsp_cause_o | output | 4 | Cause code of the last dispatch |
| dsp_err_o | output | 8 | Error code of the last dispatch |
| priv_o | output | 1 | Mode flag to adopt next |
| bad_code_o | output | 1 | Unknown exception code pulse |

## Verification
The assertions assume that every input is settled and free of X at each rising edge. They also assume the ceiling parameters keep their default values, since the machine-check property compares the level against that ceiling. They rely on the return-address and cause properties looking back exactly one cycle, which matches the single register stage. The bench changes every input only on the falling edge and holds it through the next rising edge. It reads the outputs on the falling edge that follows, so each sampled input set maps to exactly one output cycle.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned GATE_W    = 8;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned NUM_FIXED = 10;

  localparam logic [CODE_W-1:0] EC_RESET   = 4'd0;
  localparam logic [CODE_W-1:0] EC_MCHK    = 4'd1;
  localparam logic [CODE_W-1:0] EC_IPI     = 4'd2;
  localparam logic [CODE_W-1:0] EC_CLOCK   = 4'd3;
  localparam logic [CODE_W-1:0] EC_DEVICE  = 4'd4;
  localparam logic [CODE_W-1:0] EC_MEMFLT  = 4'd5;
  localparam logic [CODE_W-1:0] EC_UNALIGN = 4'd6;
  localparam logic [CODE_W-1:0] EC_ILLOP   = 4'd7;
  localparam logic [CODE_W-1:0] EC_ARITH   = 4'd8;
  localparam logic [CODE_W-1:0] EC_FPOFF   = 4'd9;
  localparam logic [CODE_W-1:0] EC_GATE    = 4'd10;
endpackage

// File: rtl/irq_vector_pick.sv
module irq_vector_pick
  import irq_vector_pkg::*;
#(
  parameter int unsigned IPL_W     = 3,
  parameter int unsigned CEIL_DEV  = 3,
  parameter int unsigned CEIL_CLK  = 4,
  parameter int unsigned CEIL_IPI  = 5,
  parameter int unsigned CEIL_MCHK = 6
) (
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [IPL_W-1:0]     ipl_i,
  input  logic                 fw_mode_i,
  output logic                 take_o,
  output logic [CODE_W-1:0]    code_o
);
  localparam int unsigned CEIL [NUM_LINES] = '{CEIL_DEV, CEIL_CLK, CEIL_IPI, CEIL_MCHK};

  logic [NUM_LINES-1:0] allow;

  // line i is open when the level does not exceed its ceiling
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_gate
    assign allow[i] = irq_i[i] && !fw_mode_i && (32'(ipl_i) <= CEIL[i]);
  end

  // higher line index wins; line i reports cause code 4 - i
  always_comb begin
    take_o = 1'b0;
    code_o = EC_RESET;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (allow[i]) begin
        take_o = 1'b1;
        code_o = CODE_W'(NUM_LINES - i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_offset.sv
module irq_vector_offset
  import irq_vector_pkg::*;
#(
  parameter int unsigned PC_W           = 64,
  parameter int unsigned VEC_STRIDE     = 128,
  parameter int unsigned SLOT_BYTES     = 64,
  parameter int unsigned GATE_PRIV_BASE = 4096,
  parameter int unsigned GATE_USER_BASE = 8192
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [GATE_W-1:0] gate_i,
  output logic              known_o,
  output logic [PC_W-1:0]   offset_o
);
  logic [PC_W-1:0] bank_base;
  logic [PC_W-1:0] slot_off;

  assign bank_base = gate_i[GATE_W-1] ? PC_W'(GATE_USER_BASE) : PC_W'(GATE_PRIV_BASE);
  assign slot_off  = PC_W'(gate_i[GATE_W-2:0]) * PC_W'(SLOT_BYTES);

  always_comb begin
    known_o  = 1'b1;
    offset_o = '0;
    if (32'(code_i) < NUM_FIXED) begin
      offset_o = PC_W'(code_i) * PC_W'(VEC_STRIDE);
    end else if (code_i == EC_GATE) begin
      offset_o = bank_base + slot_off;
    end else begin
      known_o = 1'b0;
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vector_pkg::*;
#(
  parameter int unsigned PC_W      = 64,
  parameter int unsigned IPL_W     = 3,
  parameter int unsigned CEIL_DEV  = 3,
  parameter int unsigned CEIL_CLK  = 4,
  parameter int unsigned CEIL_IPI  = 5,
  parameter int unsigned CEIL_MCHK = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        irq_i,
  input  logic [IPL_W-1:0]  ipl_i,
  input  logic              fw_mode_i,
  input  logic              exc_valid_i,
  input  logic [3:0]        exc_code_i,
  input  logic [7:0]        gate_code_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   fw_base_i,
  output logic              dsp_valid_o,
  output logic [PC_W-1:0]   dsp_pc_o,
  output logic [PC_W-1:0]   dsp_ret_o,
  output logic [3:0]        dsp_cause_o,
  output logic [7:0]        dsp_err_o,
  output logic              priv_o,
  output logic              bad_code_o
);
  logic              irq_take;
  logic [CODE_W-1:0] irq_code;
  logic [CODE_W-1:0] sel_code;
  logic              known;
  logic [PC_W-1:0]   offset;
  logic              sync_go;
  logic              irq_go;
  logic              go;

  irq_vector_pick #(
    .IPL_W(IPL_W), .CEIL_DEV(CEIL_DEV), .CEIL_CLK(CEIL_CLK),
    .CEIL_IPI(CEIL_IPI), .CEIL_MCHK(CEIL_MCHK)
  ) u_pick (
    .irq_i(irq_i), .ipl_i(ipl_i), .fw_mode_i(fw_mode_i),
    .take_o(irq_take), .code_o(irq_code)
  );

  // one offset generator shared by both dispatch sources
  assign sel_code = exc_valid_i ? exc_code_i : irq_code;

  irq_vector_offset #(.PC_W(PC_W)) u_off (
    .code_i(sel_code), .gate_i(gate_code_i),
    .known_o(known), .offset_o(offset)
  );

  assign sync_go = exc_valid_i && known;
  assign irq_go  = !exc_valid_i && irq_take;
  assign go      = sync_go || irq_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      dsp_valid_o <= 1'b0;
      dsp_pc_o    <= '0;
      dsp_ret_o   <= '0;
      dsp_cause_o <= '0;
      dsp_err_o   <= '0;
      priv_o      <= 1'b0;
      bad_code_o  <= 1'b0;
    end else begin
      dsp_valid_o <= go;
      bad_code_o  <= exc_valid_i && !known;
      priv_o      <= go ? 1'b1 : fw_mode_i;
      if (go) begin
        dsp_pc_o    <= fw_base_i + offset;
        dsp_ret_o   <= {pc_i[PC_W-1:1], pc_i[0] | fw_mode_i};
        dsp_cause_o <= sel_code;
        dsp_err_o   <= (sync_go && sel_code == EC_GATE) ? gate_code_i : '0;
      end
    end
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk
  import irq_vector_pkg::*;
#(
  parameter int unsigned PC_W      = 64,
  parameter int unsigned IPL_W     = 3,
  parameter int unsigned CEIL_MCHK = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       irq_i,
  input logic [IPL_W-1:0] ipl_i,
  input logic             fw_mode_i,
  input logic             exc_valid_i,
  input logic [3:0]       exc_code_i,
  input logic [PC_W-1:0]  pc_i,
  input logic             dsp_valid_o,
  input logic [PC_W-1:0]  dsp_ret_o,
  input logic [3:0]       dsp_cause_o,
  input logic [7:0]       dsp_err_o,
  input logic             priv_o,
  input logic             bad_code_o
);
  // R10
  bad_excl_chk: assert property (@(posedge clk) disable iff (rst)
    bad_code_o |-> !dsp_valid_o);

  // R7
  fw_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fw_mode_i) && !$past(exc_valid_i)) |-> !dsp_valid_o);

  // R4
  priv_set_chk: assert property (@(posedge clk) disable iff (rst)
    dsp_valid_o |-> priv_o);

  // R4
  ret_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && dsp_valid_o) |->
      dsp_ret_o == ($past(pc_i) | PC_W'($past(fw_mode_i))));

  // R6
  mchk_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!exc_valid_i && !fw_mode_i && irq_i[3] &&
      (32'(ipl_i) <= CEIL_MCHK))) |-> (dsp_valid_o && dsp_cause_o == EC_MCHK));

  // R8
  sync_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(exc_valid_i) && ($past(exc_code_i) <= EC_GATE)) |->
      (dsp_valid_o && dsp_cause_o == $past(exc_code_i)));

  // R9
  irq_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && dsp_valid_o && !$past(exc_valid_i)) |-> dsp_err_o == 8'd0);
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
  .PC_W(PC_W), .IPL_W(IPL_W), .CEIL_MCHK(CEIL_MCHK)
) u_chk (
  .clk(clk), .rst(rst), .irq_i(irq_i), .ipl_i(ipl_i), .fw_mode_i(fw_mode_i),
  .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i), .pc_i(pc_i),
  .dsp_valid_o(dsp_valid_o), .dsp_ret_o(dsp_ret_o), .dsp_cause_o(dsp_cause_o),
  .dsp_err_o(dsp_err_o), .priv_o(priv_o), .bad_code_o(bad_code_o)
);

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;
  localparam int PC_W = 64;
  localparam logic [63:0] BASE = 64'h0000_0000_0040_0000;
  localparam logic [63:0] PCV  = 64'hFFFF_0000_1234_5670;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] irq = '0;
  logic [2:0] ipl = '0;
  logic fw = 1'b0;
  logic ev = 1'b0;
  logic [3:0] code = '0;
  logic [7:0] gate = '0;
  logic [63:0] pc = PCV;
  logic [63:0] base = BASE;
  logic dv, pv, bad;
  logic [63:0] npc, ret;
  logic [3:0] cause;
  logic [7:0] err;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  irq_vector_unit dut (
    .clk(clk), .rst(rst), .irq_i(irq), .ipl_i(ipl), .fw_mode_i(fw),
    .exc_valid_i(ev), .exc_code_i(code), .gate_code_i(gate), .pc_i(pc),
    .fw_base_i(base), .dsp_valid_o(dv), .dsp_pc_o(npc), .dsp_ret_o(ret),
    .dsp_cause_o(cause), .dsp_err_o(err), .priv_o(pv), .bad_code_o(bad)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // drive on the falling edge, read results on the next falling edge
  task automatic fire(input logic [3:0] i_irq, input logic [2:0] i_ipl, input logic i_fw,
                      input logic i_ev, input logic [3:0] i_code, input logic [7:0] i_gate);
    irq = i_irq; ipl = i_ipl; fw = i_fw; ev = i_ev; code = i_code; gate = i_gate;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "valid", 64'(dv), 0);
    chk("R1", "pc", npc, 0);
    chk("R1", "ret", ret, 0);
    chk("R1", "priv", 64'(pv), 0);
    chk("R1", "bad", 64'(bad), 0);
    chk("R1", "cause", 64'(cause), 0);
  endtask

  task automatic t_fixed;
    logic [63:0] offs [10] = '{64'h000, 64'h080, 64'h100, 64'h180, 64'h200,
                               64'h280, 64'h300, 64'h380, 64'h400, 64'h480};
    for (int c = 0; c < 10; c++) begin
      fire(4'b0000, 3'd0, 1'b0, 1'b1, 4'(c), 8'h5A);
      chk("R2", "valid", 64'(dv), 1);
      chk("R2", "new pc", npc, BASE + offs[c]);
      chk("R2", "cause", 64'(cause), 64'(c));
      chk("R9", "err zero", 64'(err), 0);
      fire(4'b0000, 3'd0, 1'b0, 1'b0, 4'd0, 8'h00);
      chk("R2", "pulse ends", 64'(dv), 0);
    end
  endtask

  task automatic t_gate;
    logic [7:0]  g [5] = '{8'h00, 8'h05, 8'h3F, 8'h80, 8'hFF};
    logic [63:0] o [5] = '{64'h1000, 64'h1140, 64'h1FC0, 64'h2000, 64'h3FC0};
    for (int k = 0; k < 5; k++) begin
      fire(4'b0000, 3'd0, 1'b0, 1'b1, 4'd10, g[k]);
      chk("R3", "gate pc", npc, BASE + o[k]);
      chk("R9", "gate err", 64'(err), 64'(g[k]));
    end
  endtask

  task automatic t_saved;
    fire(4'b0000, 3'd0, 1'b0, 1'b1, 4'd6, 8'h00);
    chk("R4", "ret user", ret, PCV);
    chk("R4", "priv", 64'(pv), 1);
    fire(4'b0000, 3'd0, 1'b1, 1'b1, 4'd8, 8'h00);
    chk("R8", "valid in fw", 64'(dv), 1);
    chk("R4", "ret fw", ret, PCV | 64'd1);
  endtask

  task automatic t_levels;
    int ceil [4] = '{3, 4, 5, 6};
    for (int lvl = 0; lvl < 8; lvl++) begin
      for (int l = 0; l < 4; l++) begin
        fire(4'(1 << l), 3'(lvl), 1'b0, 1'b0, 4'd0, 8'h00);
        chk("R5", $sformatf("line %0d ipl %0d", l, lvl), 64'(dv), 64'(lvl <= ceil[l]));
        if (lvl <= ceil[l]) chk("R6", "line cause", 64'(cause), 64'(4 - l));
      end
    end
  endtask

  task automatic t_prio;
    fire(4'b1111, 3'd0, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R6", "all -> mchk", 64'(cause), 1);
    chk("R9", "irq err", 64'(err), 0);
    fire(4'b0111, 3'd0, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R6", "no mchk -> ipi", 64'(cause), 2);
    fire(4'b0011, 3'd4, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R6", "ipl4 -> clock", 64'(cause), 3);
    chk("R6", "ipl4 pc", npc, BASE + 64'h180);
    fire(4'b0111, 3'd6, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R5", "ipl6 no mchk", 64'(dv), 0);
  endtask

  task automatic t_fwmode;
    fire(4'b1111, 3'd0, 1'b1, 1'b0, 4'd0, 8'h00);
    chk("R7", "fw blocks irq", 64'(dv), 0);
    chk("R11", "priv follows", 64'(pv), 1);
    fire(4'b1111, 3'd0, 1'b1, 1'b1, 4'd8, 8'h00);
    chk("R8", "exc in fw", 64'(cause), 8);
    fire(4'b1000, 3'd0, 1'b0, 1'b1, 4'd5, 8'h00);
    chk("R8", "exc beats mchk", 64'(cause), 5);
    chk("R8", "exc pc", npc, BASE + 64'h280);
  endtask

  task automatic t_bad;
    fire(4'b0000, 3'd0, 1'b0, 1'b1, 4'd7, 8'h00);
    fire(4'b1111, 3'd0, 1'b0, 1'b1, 4'd12, 8'h00);
    chk("R10", "bad pulse", 64'(bad), 1);
    chk("R10", "no dispatch", 64'(dv), 0);
    chk("R10", "pc held", npc, BASE + 64'h380);
    fire(4'b0000, 3'd0, 1'b0, 1'b1, 4'd15, 8'h00);
    chk("R10", "code 15", 64'(bad), 1);
    fire(4'b0000, 3'd0, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R10", "bad ends", 64'(bad), 0);
    chk("R11", "idle priv", 64'(pv), 0);
    chk("R11", "idle cause held", 64'(cause), 7);
    chk("R11", "idle ret held", ret, PCV);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_gate();
    t_saved();
    t_levels();
    t_prio();
    t_fwmode();
    t_bad();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule